// File: doc/BRIEF.md
# Valid-Word Compaction and Round-Robin FIFO Distributor

This block takes a snapshot of sixteen input ports on every clock. Each port carries one data word, and the top bit of that word says whether the word is valid. The block gathers the valid words, keeps them in ascending port order, and writes them into a bank of sixteen downstream FIFOs at consecutive FIFO indices. The run of writes begins at a rotating write pointer. After each snapshot the pointer moves forward by the number of valid words in it, wrapping modulo the FIFO count. As a result, words from successive cycles fill the FIFOs round-robin with no gaps.

The inputs cannot be stalled, so the block accepts a new snapshot on every clock. It produces one write enable and one write-data lane per FIFO after a fixed three-register latency. Every pipeline stage carries each cycle's data words together with the routing computed for them, so words from different snapshots never mix. The FIFO storage is outside this block.

Top module: `cmpx_dist`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, every write enable is 0 and every write-data lane is 0. After reset the write pointer is 0, so the first valid word after reset goes to FIFO 0.
- R2: A port word is valid when bit WORD_W-1 is 1. A word with that bit at 0 is never written to any FIFO, whatever its other bits hold.
- R3: Within one snapshot, the valid words are written in ascending port order to consecutive FIFO indices. No FIFO receives more than one word per cycle.
- R4: After each snapshot the pointer advances by that snapshot's valid count, modulo 16. The next snapshot's first valid word goes to the FIFO that follows the last one written.
- R5: The k-th valid word (counting from 0) of a snapshot taken with pointer P goes to FIFO (P + k) mod 16, wrapping past FIFO 15 to FIFO 0.
- R6: When all 16 ports are valid, every FIFO is written exactly once in that cycle.
- R7: The number of asserted write enables equals the snapshot's valid count. A lane whose write enable is 0 drives all-zero write data.
- R8: A snapshot sampled at clock edge k appears on the FIFO outputs just after edge k+2. Snapshots presented on consecutive cycles are all processed with no stall.
- R9: A written word reaches its FIFO unchanged, including its valid bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| port_word | input | NUM_PORTS*WORD_W | Port words; port p occupies bits [p*WORD_W +: WORD_W], and its top bit is the valid flag |
| fifo_wr_en | output | NUM_PORTS | Write enable, one bit per FIFO |
| fifo_wr_data | output | NUM_PORTS*WORD_W | Write data; FIFO f occupies bits [f*WORD_W +: WORD_W] |

## Verification
The assertions assume that the port bus is driven with known values on every clock after reset. They also assume that nothing holds the inputs back, because the block has no stall path and takes every snapshot as given. The stimulus respects both: it drives every port on every cycle, including invalid words that carry non-zero payloads, and it streams its vector table back-to-back with no idle cycles between rows. It reasserts reset only at a falling clock edge, after which the asynchronous clear and the synchronous release sequence can be observed cleanly.

// File: rtl/cmpx_pkg.sv
package cmpx_pkg;

  // Registers between a port snapshot and the FIFO write outputs.
  localparam int unsigned CMPX_LATENCY = 3;

  // Add two values below 2*lim and fold the result into [0, lim).
  function automatic int unsigned fold_add(int unsigned a, int unsigned b, int unsigned lim);
    int unsigned s;
    s = a + b;
    if (s >= lim) s = s - lim;
    return s;
  endfunction

endpackage

// File: rtl/cmpx_rank.sv
// Exclusive prefix count of the valid flags, plus their total.
module cmpx_rank #(
  parameter int unsigned NUM_PORTS = 16,
  parameter int unsigned PTR_W     = 4,
  parameter int unsigned CNT_W     = 5
) (
  input  logic [NUM_PORTS-1:0]       vld,
  output logic [NUM_PORTS*PTR_W-1:0] rank,
  output logic [CNT_W-1:0]           total
);

  always_comb begin
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      rank[p*PTR_W +: PTR_W] = acc[PTR_W-1:0];
      acc = acc + {{(CNT_W-1){1'b0}}, vld[p]};
    end
    total = acc;
  end

endmodule

// File: rtl/cmpx_route.sv
// Per-FIFO selector: each FIFO picks the port whose destination matches it.
module cmpx_route #(
  parameter int unsigned NUM_PORTS = 16,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned PTR_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        vld,
  input  logic [NUM_PORTS*PTR_W-1:0]  dest,
  input  logic [NUM_PORTS*WORD_W-1:0] word,
  output logic [NUM_PORTS-1:0]        en,
  output logic [NUM_PORTS*WORD_W-1:0] data
);

  for (genvar f = 0; f < NUM_PORTS; f++) begin : g_fifo
    logic [NUM_PORTS-1:0] hit;
    logic [WORD_W-1:0]    sel;

    always_comb begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        hit[p] = vld[p] && (dest[p*PTR_W +: PTR_W] == PTR_W'(f));
      end
    end

    always_comb begin
      sel = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        sel = sel | ({WORD_W{hit[p]}} & word[p*WORD_W +: WORD_W]);
      end
    end

    assign en[f]                   = |hit;
    assign data[f*WORD_W +: WORD_W] = sel;

    // R3: the rank stage must never give two valid ports the same FIFO.
    assert_one_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
  end

endmodule

// File: rtl/cmpx_dist.sv
module cmpx_dist #(
  parameter int unsigned NUM_PORTS = 16,
  parameter int unsigned WORD_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*WORD_W-1:0] port_word,
  output logic [NUM_PORTS-1:0]        fifo_wr_en,
  output logic [NUM_PORTS*WORD_W-1:0] fifo_wr_data
);
  import cmpx_pkg::*;

  localparam int unsigned PTR_W = $clog2(NUM_PORTS);
  localparam int unsigned CNT_W = PTR_W + 1;

  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  // Stage 0: port snapshot.
  logic [NUM_PORTS*WORD_W-1:0] s0_word_d, s0_word_q;
  logic [NUM_PORTS-1:0]        s0_vld;

  assign s0_word_d = port_word;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_vld
    assign s0_vld[p] = s0_word_q[p*WORD_W + WORD_W - 1];
  end

  logic [NUM_PORTS*PTR_W-1:0] s0_rank;
  logic [CNT_W-1:0]           s0_total;

  cmpx_rank #(.NUM_PORTS(NUM_PORTS), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_rank (
    .vld   (s0_vld),
    .rank  (s0_rank),
    .total (s0_total)
  );

  // Stage 1: destination per port and pointer advance.
  logic [PTR_W-1:0]            ptr_d, ptr_q;
  logic [NUM_PORTS-1:0]        s1_vld_d, s1_vld_q;
  logic [NUM_PORTS*PTR_W-1:0]  s1_dest_d, s1_dest_q;
  logic [NUM_PORTS*WORD_W-1:0] s1_word_d, s1_word_q;

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      s1_dest_d[p*PTR_W +: PTR_W] =
        PTR_W'(fold_add(int'(ptr_q), int'(s0_rank[p*PTR_W +: PTR_W]), NUM_PORTS));
    end
    ptr_d     = PTR_W'(fold_add(int'(ptr_q), int'(s0_total), NUM_PORTS));
    s1_vld_d  = s0_vld;
    s1_word_d = s0_word_q;
  end

  // Stage 2: crossbar onto the FIFO lanes.
  logic [NUM_PORTS-1:0]        out_en_d;
  logic [NUM_PORTS*WORD_W-1:0] out_data_d;

  cmpx_route #(.NUM_PORTS(NUM_PORTS), .WORD_W(WORD_W), .PTR_W(PTR_W)) u_route (
    .clk   (clk),
    .rst_n (rst_ok),
    .vld   (s1_vld_q),
    .dest  (s1_dest_q),
    .word  (s1_word_q),
    .en    (out_en_d),
    .data  (out_data_d)
  );

  // Registers: every stage advances on every clock (no stall path).
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      s0_word_q    <= '0;
      ptr_q        <= '0;
      s1_vld_q     <= '0;
      s1_dest_q    <= '0;
      s1_word_q    <= '0;
      fifo_wr_en   <= '0;
      fifo_wr_data <= '0;
    end else begin
      s0_word_q    <= s0_word_d;
      ptr_q        <= ptr_d;
      s1_vld_q     <= s1_vld_d;
      s1_dest_q    <= s1_dest_d;
      s1_word_q    <= s1_word_d;
      fifo_wr_en   <= out_en_d;
      fifo_wr_data <= out_data_d;
    end
  end

  // R7: enables at the output match the valid count of the snapshot two edges back.
  assert_en_count_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    $countones(fifo_wr_en) == $past($countones(s0_vld), 2));

  // R6: a fully valid snapshot writes every FIFO.
  assert_full_cover_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(&s0_vld, 2) |-> &fifo_wr_en);

  for (genvar f = 0; f < NUM_PORTS; f++) begin : g_lane_chk
    // R7: idle lanes carry zero data.
    assert_idle_lane_zero_R7: assert property (@(posedge clk) disable iff (!rst_ok)
      !fifo_wr_en[f] |-> (fifo_wr_data[f*WORD_W +: WORD_W] == '0));
    // R2: only words flagged valid are ever written.
    assert_msb_set_R2: assert property (@(posedge clk) disable iff (!rst_ok)
      fifo_wr_en[f] |-> fifo_wr_data[f*WORD_W + WORD_W - 1]);
  end

endmodule

// File: tb/sim_cmpx_dist.sv
`timescale 1ns/1ps
module sim_cmpx_dist;
  localparam int NP   = 16;
  localparam int WW   = 32;
  localparam int ROWS = 8;

  // {start pointer[19:16], valid mask[15:0]}, streamed back-to-back.
  localparam logic [19:0] VEC [ROWS] = '{
    20'h0_0034,  // ports 2,4,5 -> FIFOs 0..2
    20'h3_0128,  // ports 3,5,8 -> FIFOs 3..5
    20'h6_0000,  // nothing valid
    20'h6_FFFF,  // all valid, full rotation
    20'h6_8001,  // ends only
    20'h8_7F00,  // ports 8..14
    20'hF_00FF,  // wraps from 15 to 0
    20'h7_0001
  };

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [NP*WW-1:0]     port_word;
  logic [NP-1:0]        fifo_wr_en;
  logic [NP*WW-1:0]     fifo_wr_data;
  int checks;
  int errors;

  always #2 clk = ~clk;

  cmpx_dist #(.NUM_PORTS(NP), .WORD_W(WW)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_word    (port_word),
    .fifo_wr_en   (fifo_wr_en),
    .fifo_wr_data (fifo_wr_data)
  );

  function automatic logic [WW-1:0] mk_word(int row, int p, logic v);
    return {v, (WW-1)'(row*256 + p*7 + 1)};
  endfunction

  task automatic drive_row(int row, logic [NP-1:0] m);
    for (int p = 0; p < NP; p++) port_word[p*WW +: WW] = mk_word(row, p, m[p]);
  endtask

  task automatic check_row(int row, logic [NP-1:0] m, int start, string tag);
    logic [NP-1:0]    exp_en;
    logic [NP*WW-1:0] exp_data;
    int k;
    int d;
    exp_en   = '0;
    exp_data = '0;
    k        = 0;
    for (int p = 0; p < NP; p++) begin
      if (m[p]) begin
        d = (start + k) % NP;
        exp_en[d] = 1'b1;
        exp_data[d*WW +: WW] = mk_word(row, p, 1'b1);
        k++;
      end
    end
    checks++;
    if (fifo_wr_en !== exp_en) begin
      errors++;
      $display("FAIL %s row %0d wr_en got %h exp %h", tag, row, fifo_wr_en, exp_en);
    end
    checks++;
    if (fifo_wr_data !== exp_data) begin
      errors++;
      $display("FAIL %s row %0d wr_data got %h exp %h", tag, row, fifo_wr_data, exp_data);
    end
  endtask

  task automatic check_idle(string tag);
    checks++;
    if (fifo_wr_en !== '0 || fifo_wr_data !== '0) begin
      errors++;
      $display("FAIL %s outputs got en %h data %h exp 0", tag, fifo_wr_en, fifo_wr_data);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL R8 watchdog got hang exp done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks    = 0;
    errors    = 0;
    rst_n     = 1'b0;
    port_word = '0;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1 after release");

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R9, rows streamed with no gap.
    for (int n = 0; n < ROWS + 3; n++) begin
      if (n >= 3)
        check_row(n - 3, VEC[n-3][15:0], int'(VEC[n-3][19:16]), "R3 R4 R5 R9 table");
      if (n < ROWS) drive_row(n, VEC[n][15:0]);
      else          port_word = '0;
      @(negedge clk);
    end

    // R1: reset mid-flight clears outputs and the pointer (pointer was 8).
    drive_row(20, 16'h0003);
    @(negedge clk);
    port_word = '0;
    rst_n     = 1'b0;
    @(negedge clk);
    check_idle("R1 mid reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1 no leftover");

    // R8: latency check, then R1 pointer back at FIFO 0.
    drive_row(21, 16'h0004);
    @(negedge clk);
    port_word = '0;
    @(negedge clk);
    check_idle("R8 not before edge k+2");
    @(negedge clk);
    check_row(21, 16'h0004, 0, "R1 R8 pointer reset");

    // R2: invalid-only snapshot with non-zero payloads writes nothing.
    drive_row(22, 16'h0000);
    repeat (3) @(negedge clk);
    check_row(22, 16'h0000, 1, "R2 R7 invalid payloads");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule